// File: doc/BRIEF.md
# Single-Place Shift and Rotate Unit with Condition Flags

This unit moves an operand by one bit position and reports the resulting condition flags. It handles six 8-bit operations: arithmetic and logical shifts in both directions, and left and right rotates that pass through the carry flag. It also handles one 16-bit operation, a left shift across a pair of accumulators.

The 8-bit source is one of three inputs: the high accumulator, the low accumulator or a memory byte. An operand-select input picks the source. For the 16-bit left shift, the high accumulator is the upper byte and the low accumulator is the lower byte. The bit that leaves the low byte enters the high byte.

An enable strobe captures the result and the four flags (carry, negative, zero, overflow) into registers. The surrounding datapath supplies the current carry and takes the registered result. Fetching the operand, writing it back and decoding instructions are done outside this unit.

Top module: `shift_rotate_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `result` and all four flags are 0 after that edge, whatever `en` and the data inputs are.
- R2: While `en` is low, `result` and all flags keep their values across clock edges.
- R3: Op codes 0 (arithmetic shift left) and 2 (logical shift left) give `result[7:0]` equal to the operand shifted left by one with 0 in bit 0. The new carry is the old operand bit 7.
- R4: Op code 1 (arithmetic shift right) shifts the operand right by one and keeps bit 7 at its old value. The new carry is the old bit 0.
- R5: Op code 3 (logical shift right) shifts the operand right by one with 0 in bit 7. The new carry is the old bit 0.
- R6: Op code 4 (rotate left through carry) places `carry_in` in bit 0. The old bit 7 becomes the new carry.
- R7: Op code 5 (rotate right through carry) places `carry_in` in bit 7. The old bit 0 becomes the new carry.
- R8: Op code 6 shifts the 16-bit value {`acc_a`,`acc_b`} left by one with 0 in bit 0, so that `acc_b` bit 7 lands in `result[8]`. The new carry is `acc_a` bit 7. `sel` is ignored.
- R9: For the 8-bit operations, `sel` 0 selects `acc_a`, `sel` 1 selects `acc_b`, and `sel` 2 or 3 selects `mem_in`. `result[15:8]` is 0.
- R10: After an update, `neg_out` equals the result's top bit: bit 7 for 8-bit operations and bit 15 for op code 6. `zero_out` is 1 exactly when the whole 16-bit `result` is zero.
- R11: At every clock edge, `ovf_out` equals `neg_out` XOR `carry_out`.
- R12: Op code 7 with `en` high changes neither `result` nor any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Update strobe |
| op | input | 3 | Operation code (0..7) |
| sel | input | 2 | 8-bit source select |
| acc_a | input | 8 | High accumulator |
| acc_b | input | 8 | Low accumulator |
| mem_in | input | 8 | Memory byte |
| carry_in | input | 1 | Current carry flag |
| result | output | 16 | Registered result |
| carry_out | output | 1 | Registered carry |
| neg_out | output | 1 | Registered negative flag |
| zero_out | output | 1 | Registered zero flag |
| ovf_out | output | 1 | Registered overflow flag |

## Verification
Reset and an enabled operation can arrive in the same clock cycle. The bench provokes this by raising `rst` while `en` is high and the operand is nonzero, both in directed cycles and at random during a long random run. Reset must win: the reference model expects zeros after that edge.

A second overlap comes from feeding `carry_out` back into `carry_in` on consecutive rotates. The carry written in one cycle is then consumed in the next, and the model tracks it the same way.

// File: rtl/sru_pkg.sv
package sru_pkg;

  typedef enum logic [2:0] {
    OP_SHL_ARITH = 3'd0,
    OP_SHR_ARITH = 3'd1,
    OP_SHL_LOGIC = 3'd2,
    OP_SHR_LOGIC = 3'd3,
    OP_ROT_LEFT  = 3'd4,
    OP_ROT_RIGHT = 3'd5,
    OP_SHL_WIDE  = 3'd6,
    OP_IDLE      = 3'd7
  } sru_op_e;

  typedef enum logic [1:0] {
    SRC_ACC_HI  = 2'd0,
    SRC_ACC_LO  = 2'd1,
    SRC_MEM     = 2'd2,
    SRC_MEM_ALT = 2'd3
  } sru_src_e;

  typedef struct packed {
    logic c;
    logic n;
    logic z;
    logic v;
  } sru_flags_t;

endpackage

// File: rtl/sru_operand_mux.sv
module sru_operand_mux
  import sru_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  sru_src_e            src,
  input  logic [DATA_W-1:0]   acc_hi,
  input  logic [DATA_W-1:0]   acc_lo,
  input  logic [DATA_W-1:0]   mem_byte,
  output logic [DATA_W-1:0]   operand
);

  always_comb begin
    unique case (src)
      SRC_ACC_HI: operand = acc_hi;
      SRC_ACC_LO: operand = acc_lo;
      default:    operand = mem_byte;
    endcase
  end

endmodule

// File: rtl/sru_byte_shifter.sv
module sru_byte_shifter
  import sru_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  sru_op_e             op,
  input  logic [DATA_W-1:0]   operand,
  input  logic                cin,
  output logic [DATA_W-1:0]   shifted,
  output logic                cout
);

  localparam int MSB = DATA_W - 1;

  logic               go_left;
  logic               fill_low;
  logic               fill_high;
  logic [DATA_W-1:0]  left_v;
  logic [DATA_W-1:0]  right_v;

  always_comb begin
    go_left   = (op == OP_SHL_ARITH) || (op == OP_SHL_LOGIC) || (op == OP_ROT_LEFT);
    fill_low  = (op == OP_ROT_LEFT) ? cin : 1'b0;
    unique case (op)
      OP_SHR_ARITH: fill_high = operand[MSB];
      OP_ROT_RIGHT: fill_high = cin;
      default:      fill_high = 1'b0;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == 0) begin : g_low_end
      assign left_v[i] = fill_low;
    end else begin : g_low_mid
      assign left_v[i] = operand[i-1];
    end
    if (i == MSB) begin : g_high_end
      assign right_v[i] = fill_high;
    end else begin : g_high_mid
      assign right_v[i] = operand[i+1];
    end
  end

  assign shifted = go_left ? left_v : right_v;
  assign cout    = go_left ? operand[MSB] : operand[0];

  // R5
  always_comb begin
    if (op == OP_SHR_LOGIC) begin
      lsr_fill_chk: assert (shifted[MSB] == 1'b0);
    end
  end

endmodule

// File: rtl/sru_wide_shifter.sv
module sru_wide_shifter #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]     hi_byte,
  input  logic [DATA_W-1:0]     lo_byte,
  output logic [2*DATA_W-1:0]   shifted,
  output logic                  cout
);

  localparam int WIDE_W = 2 * DATA_W;

  logic [WIDE_W-1:0] joined;
  assign joined = {hi_byte, lo_byte};

  for (genvar i = 0; i < WIDE_W; i++) begin : g_bit
    if (i == 0) begin : g_fill
      assign shifted[i] = 1'b0;
    end else begin : g_move
      assign shifted[i] = joined[i-1];
    end
  end

  assign cout = hi_byte[DATA_W-1];

endmodule

// File: rtl/sru_flag_gen.sv
module sru_flag_gen
  import sru_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2*DATA_W-1:0] value,
  input  logic                wide,
  input  logic                cin,
  output sru_flags_t          flags
);

  always_comb begin
    flags.c = cin;
    flags.n = wide ? value[2*DATA_W-1] : value[DATA_W-1];
    flags.z = ~|value;
    flags.v = flags.n ^ cin;
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [2:0]            op,
  input  logic [1:0]            sel,
  input  logic [DATA_W-1:0]     acc_a,
  input  logic [DATA_W-1:0]     acc_b,
  input  logic [DATA_W-1:0]     mem_in,
  input  logic                  carry_in,
  output logic [2*DATA_W-1:0]   result,
  output logic                  carry_out,
  output logic                  neg_out,
  output logic                  zero_out,
  output logic                  ovf_out
);

  localparam int RES_W = 2 * DATA_W;

  sru_op_e             op_e;
  sru_src_e            src_e;
  logic [DATA_W-1:0]   operand;
  logic [DATA_W-1:0]   byte_res;
  logic                byte_cout;
  logic [RES_W-1:0]    wide_res;
  logic                wide_cout;
  logic                is_wide;
  logic [RES_W-1:0]    next_res;
  logic                next_cout;
  sru_flags_t          next_flags;
  logic [RES_W-1:0]    res_q;
  sru_flags_t          flags_q;

  assign op_e  = sru_op_e'(op);
  assign src_e = sru_src_e'(sel);

  sru_operand_mux #(.DATA_W(DATA_W)) u_mux (
    .src      (src_e),
    .acc_hi   (acc_a),
    .acc_lo   (acc_b),
    .mem_byte (mem_in),
    .operand  (operand)
  );

  sru_byte_shifter #(.DATA_W(DATA_W)) u_byte (
    .op      (op_e),
    .operand (operand),
    .cin     (carry_in),
    .shifted (byte_res),
    .cout    (byte_cout)
  );

  sru_wide_shifter #(.DATA_W(DATA_W)) u_wide (
    .hi_byte (acc_a),
    .lo_byte (acc_b),
    .shifted (wide_res),
    .cout    (wide_cout)
  );

  assign is_wide   = (op_e == OP_SHL_WIDE);
  assign next_res  = is_wide ? wide_res : {{DATA_W{1'b0}}, byte_res};
  assign next_cout = is_wide ? wide_cout : byte_cout;

  sru_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .value (next_res),
    .wide  (is_wide),
    .cin   (next_cout),
    .flags (next_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (en && (op_e != OP_IDLE)) begin
      res_q   <= next_res;
      flags_q <= next_flags;
    end
  end

  assign result    = res_q;
  assign carry_out = flags_q.c;
  assign neg_out   = flags_q.n;
  assign zero_out  = flags_q.z;
  assign ovf_out   = flags_q.v;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && !carry_out && !neg_out && !zero_out && !ovf_out));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(result) && $stable(carry_out) && $stable(neg_out) && $stable(zero_out)));

  // R12
  reserved_op_chk: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd7) |=> ($stable(result) && $stable(carry_out) && $stable(zero_out)));

  // R11
  ovf_relation_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_out == (neg_out ^ carry_out));

  // R4
  asr_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd1) |=> (result[DATA_W-1] == result[DATA_W-2]));

  // R6
  rol_carry_in_chk: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd4) |=> (result[0] == $past(carry_in)));

  // R8
  wide_link_chk: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd6) |=> (carry_out == $past(acc_a[DATA_W-1]) &&
                            result[DATA_W] == $past(acc_b[DATA_W-1])));

endmodule

// File: tb/shift_rotate_unit_test.sv
module shift_rotate_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [1:0]  sel = 2'd0;
  logic [7:0]  acc_a = 8'd0;
  logic [7:0]  acc_b = 8'd0;
  logic [7:0]  mem_in = 8'd0;
  logic        carry_in = 1'b0;
  logic [15:0] result;
  logic        carry_out, neg_out, zero_out, ovf_out;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  int    e_res = 0;
  bit    e_c = 0, e_n = 0, e_z = 0, e_v = 0;
  string e_tag = "R1 reset";

  always #2.5 clk = ~clk;

  shift_rotate_unit uut (
    .clk(clk), .rst(rst), .en(en), .op(op), .sel(sel),
    .acc_a(acc_a), .acc_b(acc_b), .mem_in(mem_in), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .neg_out(neg_out),
    .zero_out(zero_out), .ovf_out(ovf_out)
  );

  // Behavioural reference model, updated at each rising edge.
  always @(posedge clk) begin : model
    int v, r, w;
    bit c;
    if (rst) begin
      e_res = 0; e_c = 0; e_n = 0; e_z = 0; e_v = 0;
      e_tag = "R1 reset";
    end else if (!en) begin
      e_tag = "R2 hold";
    end else if (op == 3'd7) begin
      e_tag = "R12 reserved op";
    end else begin
      v = (sel == 2'd0) ? int'(acc_a) : (sel == 2'd1) ? int'(acc_b) : int'(mem_in);
      r = 0; c = 0;
      case (op)
        3'd0, 3'd2: begin r = (v * 2) % 256; c = bit'(v / 128); e_tag = "R3 shl R9 R10 R11"; end
        3'd1: begin r = (v / 2) + (v / 128) * 128; c = bit'(v % 2); e_tag = "R4 asr R9 R10 R11"; end
        3'd3: begin r = v / 2; c = bit'(v % 2); e_tag = "R5 lsr R9 R10 R11"; end
        3'd4: begin r = (v * 2) % 256 + int'(carry_in); c = bit'(v / 128); e_tag = "R6 rol R9 R10 R11"; end
        3'd5: begin r = v / 2 + int'(carry_in) * 128; c = bit'(v % 2); e_tag = "R7 ror R9 R10 R11"; end
        default: begin
          w = int'(acc_a) * 256 + int'(acc_b);
          r = (w * 2) % 65536; c = bit'(int'(acc_a) / 128); e_tag = "R8 wide R10 R11";
        end
      endcase
      e_res = r;
      e_c   = c;
      e_n   = (op == 3'd6) ? bit'(r / 32768) : bit'(r / 128);
      e_z   = (r == 0);
      e_v   = e_n ^ e_c;
    end
  end

  task automatic compare();
    n_chk++;
    if (int'(result) != e_res || carry_out != e_c || neg_out != e_n ||
        zero_out != e_z || ovf_out != e_v) begin
      n_fail++;
      $display("FAIL %s: got result=%h c=%b n=%b z=%b v=%b, expected result=%h c=%b n=%b z=%b v=%b",
               e_tag, result, carry_out, neg_out, zero_out, ovf_out,
               e_res[15:0], e_c, e_n, e_z, e_v);
    end
  endtask

  task automatic step(input bit r, input bit e, input logic [2:0] o, input logic [1:0] s,
                      input logic [7:0] a, input logic [7:0] b, input logic [7:0] m,
                      input bit ci);
    @(negedge clk);
    compare();
    rst = r; en = e; op = o; sel = s; acc_a = a; acc_b = b; mem_in = m; carry_in = ci;
  endtask

  initial begin
    // R1: reset state checked at first compare
    step(1, 0, 3'd0, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    // R1: reset wins over an enabled operation in the same cycle
    step(1, 1, 3'd0, 2'd0, 8'hC3, 8'h5A, 8'h77, 1);
    // R3 and R9: sources A, B, memory
    step(0, 1, 3'd0, 2'd0, 8'hC3, 8'h5A, 8'h77, 0);
    step(0, 1, 3'd2, 2'd1, 8'hC3, 8'h5A, 8'h77, 1);
    step(0, 1, 3'd0, 2'd2, 8'hC3, 8'h5A, 8'h80, 0);
    // R4: negative stays negative
    step(0, 1, 3'd1, 2'd3, 8'h00, 8'h00, 8'h81, 0);
    // R5: 0x01 gives zero result with carry
    step(0, 1, 3'd3, 2'd0, 8'h01, 8'hFF, 8'h00, 1);
    // R6 and R7 with carry set and clear
    step(0, 1, 3'd4, 2'd1, 8'h00, 8'hFF, 8'h00, 1);
    step(0, 1, 3'd4, 2'd1, 8'h00, 8'h80, 8'h00, 0);
    step(0, 1, 3'd5, 2'd2, 8'h00, 8'h00, 8'h01, 1);
    step(0, 1, 3'd5, 2'd0, 8'h00, 8'h00, 8'h00, 0);
    // R8: cross-byte carry and full-zero result
    step(0, 1, 3'd6, 2'd2, 8'h80, 8'h00, 8'hFF, 0);
    step(0, 1, 3'd6, 2'd1, 8'h40, 8'h80, 8'h00, 1);
    // R2: enable low holds
    step(0, 0, 3'd0, 2'd0, 8'hFF, 8'hFF, 8'hFF, 1);
    // R12: reserved op holds
    step(0, 1, 3'd7, 2'd0, 8'h12, 8'h34, 8'h56, 1);
    step(0, 1, 3'd7, 2'd1, 8'hFF, 8'h00, 8'h00, 0);
    // Random run, carry fed back half of the time
    for (int i = 0; i < 3000; i++) begin
      bit fb;
      fb = ($urandom % 2) == 0;
      step(($urandom % 50) == 0, ($urandom % 10) != 0, 3'($urandom % 8), 2'($urandom % 4),
           8'($urandom), 8'($urandom), 8'($urandom), fb ? carry_out : 1'($urandom));
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule